// File: doc/BRIEF.md
# Rail Fault Monitor with Retry

This block supervises one power rail. It receives a 10-bit voltage sample each clock cycle, compares it with an undervoltage and an overvoltage limit, and tracks how long the rail stays outside that window. A short excursion is a glitch. One that lasts the configured width is a sustained fault. After the rail is switched on it must reach the window within a maximum time; if it does not, that is a failed start. Each fault is then handled in one of six ways: ignore it, log it, retry a limited number of times, retry without limit, request a full resequence, or retry a limited number of times and then request a resequence.

The sequencer drives `seq_en` to ask for the rail. The block answers with `rail_en`, which drives the supply enable. It also produces one-cycle pulses that ask for dependent outputs to shut down, ask for everything to shut down at once, or ask for a system restart. A log strobe carries a two-bit fault kind. Averaging of the samples and storage of the log are done elsewhere.

Top module: `rail_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `rail_en`, `log_stb`, `dep_shdn`, `all_shdn` and `reseq_req` are all 0.
- R2: One cycle after `seq_en` rises, `rail_en` is 1. One cycle after `seq_en` is low, `rail_en` is 0. Low `seq_en` overrides every other input.
- R3: A sample inside the window `uv_lim <= sample <= ov_lim`, bounds included, is in regulation. A sample below `uv_lim` is fault kind 1 (undervoltage). A sample above `ov_lim` is fault kind 2 (overvoltage).
- R4: Once the rail is regulated, a sample that stays outside the window for `glitch_w` consecutive cycles is a sustained fault. Its log strobe appears exactly `glitch_w` cycles after the first such sample.
- R5: An excursion that lasts L cycles, with 1 <= L < `glitch_w`, is a glitch. It logs kind 0 in the cycle after the sample returns to the window, unless `glitch_mask` is 1. A glitch never changes `rail_en`.
- R6: If the rail is not in the window within `mtfr` cycles of being switched on, a failed start is logged with kind 3, `mtfr`+1 cycles after `seq_en` rises.
- R7: Mode 2 (limited retry): on a fault, `rail_en` goes low for exactly OFF_US microseconds of clock cycles and then comes back on. At most `retry_n` retries are made (values above 4 count as 4). The next fault after that pulses `dep_shdn` and holds the rail off.
- R8: Mode 3 (endless retry): the off/on cycle repeats without `dep_shdn` until the rail regulates. After that the rail stays on.
- R9: Mode 4 (resequence): a fault pulses `all_shdn` and `reseq_req` together. In the same cycle `rail_en` drops and `dep_shdn` stays 0. The rail then stays off.
- R10: Mode 5 (limited retry, then resequence) behaves like mode 2, but `reseq_req` pulses together with `dep_shdn`. A `parent_kill` in mode 5 also pulses `reseq_req`.
- R11: Mode 0 (ignore) produces no log strobe and leaves `rail_en` on after any fault. Mode 1 (log only) logs every fault and glitch and also leaves `rail_en` on.
- R12: A `parent_kill` pulse while the rail is active turns `rail_en` off one cycle later. It does not pulse `dep_shdn`. The rail stays off until `seq_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_en | input | 1 | Sequencer request to turn the rail on |
| parent_kill | input | 1 | Forced shutdown caused by a parent rail |
| sample | input | VW (10) | Averaged rail voltage code |
| uv_lim | input | VW (10) | Undervoltage limit (lowest in-regulation code) |
| ov_lim | input | VW (10) | Overvoltage limit (highest in-regulation code) |
| glitch_w | input | GW_W (8) | Cycles out of window that make a sustained fault, at least 1 |
| mtfr | input | TMR_W (16) | Cycles allowed to reach regulation, at least 1 |
| mode | input | 3 | Response: 0 ignore, 1 log, 2 retry n, 3 retry forever, 4 resequence, 5 retry n then resequence |
| retry_n | input | TRY_W (3) | Retry budget for modes 2 and 5 |
| glitch_mask | input | 1 | Suppresses glitch log events |
| rail_en | output | 1 | Supply enable |
| log_stb | output | 1 | One-cycle log event |
| log_kind | output | 2 | 0 glitch, 1 undervoltage, 2 overvoltage, 3 failed start |
| dep_shdn | output | 1 | Pulse: shut down dependent outputs |
| all_shdn | output | 1 | Pulse: shut down everything at once |
| reseq_req | output | 1 | Pulse: request a system restart |

## Verification
The assertions assume that `mode`, `retry_n`, `glitch_w` and `mtfr` change only while `seq_en` is low or while no excursion is being counted. They also assume that `glitch_w` and `mtfr` are never zero. The bench respects this by writing configuration only with the rail idle, or with the sample back in the window and the glitch count cleared. Inputs change only at falling edges. A sweep then covers every glitch length below each width from 2 to 5, with glitch masking on and off. It also covers every retry budget from 0 to 4 in both limited-retry modes, and every start timeout from 1 to 6.

// File: rtl/rail_pkg.sv
package rail_pkg;

    typedef enum logic [2:0] {
        M_IGNORE      = 3'd0,
        M_LOG         = 3'd1,
        M_RETRY       = 3'd2,
        M_CONT        = 3'd3,
        M_SEQ         = 3'd4,
        M_RETRY_RESEQ = 3'd5
    } resp_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RAMP = 3'd1,
        S_RUN  = 3'd2,
        S_OFF  = 3'd3,
        S_HALT = 3'd4
    } st_e;

    typedef enum logic [1:0] {
        K_GLITCH  = 2'd0,
        K_UV      = 2'd1,
        K_OV      = 2'd2,
        K_NOSTART = 2'd3
    } kind_e;

endpackage

// File: rtl/rail_window.sv
module rail_window
    import rail_pkg::*;
#(
    parameter int VW = 10
) (
    input  logic [VW-1:0] sample,
    input  logic [VW-1:0] uv_lim,
    input  logic [VW-1:0] ov_lim,
    output logic          oor,
    output kind_e         oor_kind
);

    always_comb begin
        oor      = 1'b0;
        oor_kind = K_GLITCH;
        if (sample < uv_lim) begin
            oor      = 1'b1;
            oor_kind = K_UV;
        end else if (sample > ov_lim) begin
            oor      = 1'b1;
            oor_kind = K_OV;
        end
    end

    always_comb begin
        assert_kind_match_R3: assert (oor == (oor_kind != K_GLITCH));
    end

endmodule

// File: rtl/rail_glitch_filter.sv
module rail_glitch_filter #(
    parameter int GW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            oor,
    input  logic [GW_W-1:0] width,
    output logic            sustained,
    output logic            glitch
);

    logic [GW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        sustained = active && oor && ((cnt_q + 1'b1) == width);
        glitch    = active && !oor && (cnt_q != '0);
        if (!active || sustained || !oor) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_cnt_under_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < width));

    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

endmodule

// File: rtl/rail_resp_fsm.sv
module rail_resp_fsm
    import rail_pkg::*;
#(
    parameter int TMR_W      = 16,
    parameter int MAX_RETRY  = 4,
    parameter int OFF_CYCLES = 100000,
    localparam int TRY_W     = $clog2(MAX_RETRY + 1),
    localparam int OFF_W     = $clog2(OFF_CYCLES + 1),
    localparam int CW        = (TMR_W > OFF_W) ? TMR_W : OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_en,
    input  logic             parent_kill,
    input  logic             oor,
    input  kind_e            oor_kind,
    input  logic             sustained,
    input  logic             glitch,
    input  logic [TMR_W-1:0] mtfr,
    input  logic [2:0]       mode,
    input  logic [TRY_W-1:0] retry_n,
    input  logic             glitch_mask,
    output logic             mon_active,
    output logic             rail_en,
    output logic             log_stb,
    output kind_e            log_kind,
    output logic             dep_shdn,
    output logic             all_shdn,
    output logic             reseq_req
);

    localparam logic [CW-1:0]    ONE      = CW'(1);
    localparam logic [CW-1:0]    OFF_LAST = CW'(OFF_CYCLES - 1);
    localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_RETRY);

    typedef struct packed {
        st_e              st;
        logic [CW-1:0]    tmr;
        logic [TRY_W-1:0] tries;
        logic             rail_en;
        logic             log_stb;
        kind_e            log_kind;
        logic             dep_shdn;
        logic             all_shdn;
        logic             reseq;
    } fsm_t;

    fsm_t r_d, r_q;
    logic             fault;
    kind_e            fkind;
    logic [TRY_W-1:0] n_lim;
    logic             active_st;

    always_comb begin
        n_lim     = (retry_n > TRY_MAX) ? TRY_MAX : retry_n;
        active_st = (r_q.st == S_RAMP) || (r_q.st == S_RUN) || (r_q.st == S_OFF);
        r_d          = r_q;
        r_d.log_stb  = 1'b0;
        r_d.dep_shdn = 1'b0;
        r_d.all_shdn = 1'b0;
        r_d.reseq    = 1'b0;
        fault        = 1'b0;
        fkind        = K_GLITCH;

        if (!seq_en) begin
            r_d.st      = S_IDLE;
            r_d.tmr     = '0;
            r_d.tries   = '0;
            r_d.rail_en = 1'b0;
        end else if (parent_kill && active_st) begin
            r_d.st      = S_HALT;
            r_d.rail_en = 1'b0;
            r_d.reseq   = (mode == M_RETRY_RESEQ);
        end else begin
            case (r_q.st)
                S_IDLE: begin
                    r_d.st      = S_RAMP;
                    r_d.tmr     = '0;
                    r_d.rail_en = 1'b1;
                end
                S_RAMP: begin
                    if (!oor) begin
                        r_d.st    = S_RUN;
                        r_d.tries = '0;
                    end else if ((r_q.tmr + ONE) == CW'(mtfr)) begin
                        fault = 1'b1;
                        fkind = K_NOSTART;
                    end else begin
                        r_d.tmr = r_q.tmr + ONE;
                    end
                end
                S_RUN: begin
                    if (sustained) begin
                        fault = 1'b1;
                        fkind = oor_kind;
                    end else if (glitch && !glitch_mask && (mode != M_IGNORE)) begin
                        r_d.log_stb  = 1'b1;
                        r_d.log_kind = K_GLITCH;
                    end
                end
                S_OFF: begin
                    if (r_q.tmr == OFF_LAST) begin
                        r_d.st      = S_RAMP;
                        r_d.tmr     = '0;
                        r_d.rail_en = 1'b1;
                    end else begin
                        r_d.tmr = r_q.tmr + ONE;
                    end
                end
                default: ;
            endcase
        end

        if (fault) begin
            if (mode != M_IGNORE) begin
                r_d.log_stb  = 1'b1;
                r_d.log_kind = fkind;
            end
            case (mode)
                M_IGNORE, M_LOG: begin
                    r_d.st  = S_RUN;
                    r_d.tmr = '0;
                end
                M_RETRY, M_RETRY_RESEQ: begin
                    r_d.rail_en = 1'b0;
                    r_d.tmr     = '0;
                    if (r_q.tries < n_lim) begin
                        r_d.st    = S_OFF;
                        r_d.tries = r_q.tries + 1'b1;
                    end else begin
                        r_d.st       = S_HALT;
                        r_d.dep_shdn = 1'b1;
                        r_d.reseq    = (mode == M_RETRY_RESEQ);
                    end
                end
                M_CONT: begin
                    r_d.st      = S_OFF;
                    r_d.tmr     = '0;
                    r_d.rail_en = 1'b0;
                end
                default: begin
                    r_d.st       = S_HALT;
                    r_d.rail_en  = 1'b0;
                    r_d.all_shdn = 1'b1;
                    r_d.reseq    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, tmr: '0, tries: '0, rail_en: 1'b0, log_stb: 1'b0,
                     log_kind: K_GLITCH, dep_shdn: 1'b0, all_shdn: 1'b0, reseq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mon_active = (r_q.st == S_RUN);
    assign rail_en    = r_q.rail_en;
    assign log_stb    = r_q.log_stb;
    assign log_kind   = r_q.log_kind;
    assign dep_shdn   = r_q.dep_shdn;
    assign all_shdn   = r_q.all_shdn;
    assign reseq_req  = r_q.reseq;

    assert_seq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en |=> !rail_en);

    assert_tries_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tries <= TRY_MAX);

    assert_off_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_OFF) |-> (r_q.tmr <= OFF_LAST && !rail_en));

    assert_shdn_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dep_shdn, all_shdn}));

    assert_all_with_reseq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        all_shdn |-> (reseq_req && !rail_en));

    assert_ignore_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IGNORE) |=> !log_stb);

    assert_dep_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dep_shdn |-> !rail_en);

endmodule

// File: rtl/rail_guard.sv
module rail_guard
    import rail_pkg::*;
#(
    parameter int VW        = 10,
    parameter int TMR_W     = 16,
    parameter int GW_W      = 8,
    parameter int MAX_RETRY = 4,
    parameter int CLK_HZ    = 100_000_000,
    parameter int OFF_US    = 1000,
    localparam int TRY_W    = $clog2(MAX_RETRY + 1),
    localparam int OFF_CYC  = (CLK_HZ / 1_000_000) * OFF_US
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_en,
    input  logic             parent_kill,
    input  logic [VW-1:0]    sample,
    input  logic [VW-1:0]    uv_lim,
    input  logic [VW-1:0]    ov_lim,
    input  logic [GW_W-1:0]  glitch_w,
    input  logic [TMR_W-1:0] mtfr,
    input  logic [2:0]       mode,
    input  logic [TRY_W-1:0] retry_n,
    input  logic             glitch_mask,
    output logic             rail_en,
    output logic             log_stb,
    output logic [1:0]       log_kind,
    output logic             dep_shdn,
    output logic             all_shdn,
    output logic             reseq_req
);

    logic  oor, sustained, glitch, mon_active;
    kind_e oor_kind, kind_q;

    rail_window #(.VW(VW)) u_win (
        .sample   (sample),
        .uv_lim   (uv_lim),
        .ov_lim   (ov_lim),
        .oor      (oor),
        .oor_kind (oor_kind)
    );

    rail_glitch_filter #(.GW_W(GW_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mon_active),
        .oor       (oor),
        .width     (glitch_w),
        .sustained (sustained),
        .glitch    (glitch)
    );

    rail_resp_fsm #(
        .TMR_W      (TMR_W),
        .MAX_RETRY  (MAX_RETRY),
        .OFF_CYCLES (OFF_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .seq_en      (seq_en),
        .parent_kill (parent_kill),
        .oor         (oor),
        .oor_kind    (oor_kind),
        .sustained   (sustained),
        .glitch      (glitch),
        .mtfr        (mtfr),
        .mode        (mode),
        .retry_n     (retry_n),
        .glitch_mask (glitch_mask),
        .mon_active  (mon_active),
        .rail_en     (rail_en),
        .log_stb     (log_stb),
        .log_kind    (kind_q),
        .dep_shdn    (dep_shdn),
        .all_shdn    (all_shdn),
        .reseq_req   (reseq_req)
    );

    assign log_kind = kind_q;

    assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(rail_en || log_stb || dep_shdn || all_shdn || reseq_req));

    assert_fault_needs_oor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sustained |=> !mon_active || log_stb || (mode == M_IGNORE) || !$past(seq_en) || $past(parent_kill));

endmodule

// File: tb/sim_rail_guard.sv
module sim_rail_guard;

    localparam int VW = 10, TMR_W = 8, GW_W = 4, MAX_RETRY = 4;
    localparam int CLK_HZ = 100_000_000, OFF_US = 1;
    localparam int OFF_EXP = (CLK_HZ / 1_000_000) * OFF_US;

    logic clk = 1'b0, rst_n = 1'b0;
    logic seq_en = 1'b0, parent_kill = 1'b0, glitch_mask = 1'b0;
    logic [VW-1:0] sample = 10'd500, uv_lim = 10'd200, ov_lim = 10'd800;
    logic [GW_W-1:0] glitch_w = 4'd3;
    logic [TMR_W-1:0] mtfr = 8'd4;
    logic [2:0] mode = 3'd1, retry_n = 3'd0;
    logic rail_en, log_stb, dep_shdn, all_shdn, reseq_req;
    logic [1:0] log_kind;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int c_log = 0, c_rise = 0, c_dep = 0, c_all = 0, c_rsq = 0;
    int low_run = 0, last_off = 0;
    logic prev_en = 1'b0;

    always #5 clk = ~clk;

    rail_guard #(.VW(VW), .TMR_W(TMR_W), .GW_W(GW_W), .MAX_RETRY(MAX_RETRY),
                 .CLK_HZ(CLK_HZ), .OFF_US(OFF_US)) u0 (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .parent_kill(parent_kill),
        .sample(sample), .uv_lim(uv_lim), .ov_lim(ov_lim), .glitch_w(glitch_w),
        .mtfr(mtfr), .mode(mode), .retry_n(retry_n), .glitch_mask(glitch_mask),
        .rail_en(rail_en), .log_stb(log_stb), .log_kind(log_kind),
        .dep_shdn(dep_shdn), .all_shdn(all_shdn), .reseq_req(reseq_req));

    // event monitor, sampled 2 ns after each rising edge
    always begin
        @(posedge clk);
        #2;
        cyc++;
        if (log_stb) c_log++;
        if (dep_shdn) c_dep++;
        if (all_shdn) c_all++;
        if (reseq_req) c_rsq++;
        if (rail_en && !prev_en) begin
            c_rise++;
            last_off = low_run;
        end
        low_run = rail_en ? 0 : low_run + 1;
        prev_en = rail_en;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always begin
        @(posedge clk);
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
            summary();
        end
    end

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        seq_en = 1'b0;
        sample = 10'd500;
        step(3);
    endtask

    task automatic bring_up();
        sample = 10'd500;
        seq_en = 1'b1;
        step(4);
    endtask

    task automatic wait_log(output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (!log_stb && n < 60);
    endtask

    initial begin
        int n, l0, r0, d0, a0, q0;
        step(3);
        chk("R1 reset outputs", {rail_en, log_stb, dep_shdn, all_shdn, reseq_req}, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 after release", {rail_en, log_stb, dep_shdn, all_shdn, reseq_req}, 0);

        // R2 enable follows request
        mode = 3'd1;
        seq_en = 1'b1;
        step(1);
        chk("R2 on after request", rail_en, 1);
        step(3);
        seq_en = 1'b0;
        step(1);
        chk("R2 off after drop", rail_en, 0);
        step(2);

        // R3 window bounds inclusive
        bring_up();
        l0 = c_log;
        sample = uv_lim; step(10);
        sample = ov_lim; step(10);
        chk("R3 bounds in regulation", c_log - l0, 0);

        // R3/R4 sustained sweep
        for (int w = 2; w <= 5; w++) begin
            for (int k = 1; k <= 2; k++) begin
                sample = 10'd500;
                glitch_w = GW_W'(w);
                step(2);
                sample = (k == 1) ? 10'd199 : 10'd801;
                wait_log(n);
                sample = 10'd500;
                chk($sformatf("R4 sustained delay w=%0d", w), n, w);
                chk("R3 fault kind", log_kind, k);
                chk("R11 log mode keeps rail", rail_en, 1);
                step(3);
            end
        end

        // R5 glitch sweep
        for (int w = 2; w <= 5; w++) begin
            for (int len = 1; len < w; len++) begin
                for (int m = 0; m <= 1; m++) begin
                    glitch_w = GW_W'(w);
                    glitch_mask = m[0];
                    step(1);
                    l0 = c_log;
                    sample = 10'd150;
                    step(len);
                    chk("R5 no log during glitch", c_log - l0, 0);
                    sample = 10'd500;
                    step(1);
                    chk($sformatf("R5 glitch log w=%0d len=%0d mask=%0d", w, len, m),
                        log_stb, (m == 0) ? 1 : 0);
                    if (m == 0) chk("R5 glitch kind", log_kind, 0);
                    chk("R5 rail stays on", rail_en, 1);
                    step(3);
                end
            end
        end
        glitch_mask = 1'b0;
        glitch_w = 4'd3;
        go_idle();

        // R6 failed start sweep
        for (int t = 1; t <= 6; t++) begin
            mtfr = TMR_W'(t);
            sample = 10'd100;
            seq_en = 1'b1;
            wait_log(n);
            chk($sformatf("R6 no-start delay mtfr=%0d", t), n, t + 1);
            chk("R6 no-start kind", log_kind, 3);
            chk("R11 log-only rail stays on", rail_en, 1);
            go_idle();
        end
        mtfr = 8'd4;

        // R7 / R10 limited retry sweep
        for (int m = 2; m <= 5; m += 3) begin
            for (int r = 0; r <= 4; r++) begin
                mode = 3'(m);
                retry_n = 3'(r);
                step(1);
                l0 = c_log; r0 = c_rise; d0 = c_dep; q0 = c_rsq;
                sample = 10'd100;
                seq_en = 1'b1;
                n = 0;
                while (c_dep == d0 && n < 3000) begin
                    step(1);
                    n++;
                end
                step(20);
                tag_retry: begin
                    chk($sformatf("R7 enables mode=%0d n=%0d", m, r), c_rise - r0, r + 1);
                    chk("R7 fault logs", c_log - l0, r + 1);
                    chk("R7 dependent shutdown", c_dep - d0, 1);
                    chk("R10 resequence request", c_rsq - q0, (m == 5) ? 1 : 0);
                    chk("R7 rail held off", rail_en, 0);
                    if (r > 0) chk("R7 off time", last_off, OFF_EXP);
                end
                go_idle();
            end
        end
        // retry budget above 4 counts as 4
        mode = 3'd2; retry_n = 3'd7; step(1);
        r0 = c_rise; d0 = c_dep;
        sample = 10'd100; seq_en = 1'b1;
        step(1500);
        chk("R7 budget clamp", c_rise - r0, 5);
        chk("R7 clamp dep", c_dep - d0, 1);
        go_idle();

        // R8 endless retry
        mode = 3'd3; step(1);
        r0 = c_rise; d0 = c_dep;
        sample = 10'd100; seq_en = 1'b1;
        step(800);
        chk("R8 repeated enables", (c_rise - r0) >= 6 ? 1 : 0, 1);
        chk("R8 no dependent shutdown", c_dep - d0, 0);
        sample = 10'd500;
        step(300);
        r0 = c_rise;
        step(200);
        chk("R8 regulated stays on", rail_en, 1);
        chk("R8 no further retries", c_rise - r0, 0);
        go_idle();

        // R9 resequence
        mode = 3'd4; glitch_w = 4'd3; step(1);
        bring_up();
        d0 = c_dep; a0 = c_all;
        sample = 10'd900;
        wait_log(n);
        chk("R9 fault delay", n, 3);
        chk("R9 all shutdown", all_shdn, 1);
        chk("R9 reseq", reseq_req, 1);
        chk("R9 rail off", rail_en, 0);
        chk("R9 kind", log_kind, 2);
        step(20);
        chk("R9 no dep", c_dep - d0, 0);
        chk("R9 single all", c_all - a0, 1);
        chk("R9 stays off", rail_en, 0);
        go_idle();

        // R11 ignore
        mode = 3'd0; step(1);
        l0 = c_log;
        sample = 10'd100; seq_en = 1'b1;
        step(100);
        sample = 10'd900;
        step(50);
        sample = 10'd500;
        step(2); sample = 10'd150; step(1); sample = 10'd500; step(3);
        chk("R11 ignore no logs", c_log - l0, 0);
        chk("R11 ignore rail on", rail_en, 1);
        go_idle();

        // R12 / R10 parent shutdown
        for (int m = 2; m <= 5; m += 3) begin
            mode = 3'(m); step(1);
            bring_up();
            d0 = c_dep; q0 = c_rsq;
            parent_kill = 1'b1;
            step(1);
            parent_kill = 1'b0;
            chk("R12 parent off", rail_en, 0);
            chk("R10 parent reseq", reseq_req, (m == 5) ? 1 : 0);
            step(20);
            chk("R12 stays off", rail_en, 0);
            chk("R12 no dep", c_dep - d0, 0);
            chk("R10 reseq count", c_rsq - q0, (m == 5) ? 1 : 0);
            seq_en = 1'b0; step(2);
            seq_en = 1'b1; step(1);
            chk("R12 recovers after drop", rail_en, 1);
            go_idle();
        end

        summary();
    end

endmodule